// File: doc/BRIEF.md
# Interrupt cause and mask register bank

This block keeps the pending interrupt state for a group of up to 32 sources and exposes it to software as seven 32-bit registers on a simple synchronous bus. Each source owns one bit position, and that position means the same source in every register. A hardware event pulse latches the source's cause bit. Software can also raise a cause by writing the set register.

Each bit is acknowledged in one of two ways, and software picks the way per bit. In write-one-to-clear mode a one written to the cause or masked-cause register clears the bit. In clear-on-read mode a read of either register clears the bits that the read returned as set. The mask can be written as a whole word, or changed one bit at a time through the set-only and clear-only registers, so that concurrent agents need no read-modify-write. The masked cause view is cause AND NOT mask, and a single level interrupt line is high while any bit of that view is set.

Read data is combinational: it is valid in the same cycle as the read strobe. All register updates, including clear-on-read, take effect at the clock edge that ends the access.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset every cause bit is 0, every mask bit is 1, every mode bit is 0, and the interrupt output is low.
- R2: An event input bit at 1 during a clock edge sets the matching cause bit; the bit stays set until software clears it.
- R3: A write to the cause word (byte offset 0x04) or the masked-cause word (0x08) clears each cause bit whose write data bit is 1 and whose mode bit is 0; bits with mode 1 are not changed by writes.
- R4: A read of the cause word (0x04) returns the cause bits and clears each returned 1 whose mode bit is 1; bits with mode 0 are not changed by reads.
- R5: A read of the masked-cause word (0x08) returns cause AND NOT mask and clears, among the returned 1s, those whose mode bit is 1.
- R6: A write to the cause-set word (0x0C) sets each cause bit whose data bit is 1. Reads of 0x0C, 0x14, 0x18 and of any unmapped word return 0.
- R7: The mask word (0x10) is read and written directly; a mask bit of 1 hides its cause from the masked view.
- R8: Writing 1s to the mask-set word (0x14) sets those mask bits; writing 1s to the mask-clear word (0x18) clears them; 0 data bits leave the mask unchanged.
- R9: When an event or a cause-set write hits a bit in the same cycle as a clear of that bit, the bit ends set.
- R10: The interrupt output is high exactly when some cause bit is 1 while its mask bit is 0.
- R11: The mode word (0x00) is read and written directly; mode bit 0 selects write-one-to-clear, 1 selects clear-on-read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Hardware event pulses, one per source |
| bus_addr | input | 5 | Byte address of the accessed word |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid while bus_re is high, else 0 |
| irq_o | output | 1 | Level interrupt request |

## Verification
The properties assume that the event inputs and bus strobes are sampled only at rising edges, that the two low address bits are don't-care, and that the event vector is quiet in the cycle of an access whose clearing they check, since a simultaneous event is meant to win over the clear. The stimulus holds the event vector at zero during reset and on the directed clearing accesses, and lets the random phase mix reads, writes and events freely, with a reference model that applies the set-wins rule so that overlapping events and clears are also covered.

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  evt_i,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_re,
  output logic [W-1:0]  bus_rdata,
  output logic          irq_o
);
  localparam int IW = AW - 2;
  localparam logic [IW-1:0] A_MODE  = IW'(0);
  localparam logic [IW-1:0] A_CAUSE = IW'(1);
  localparam logic [IW-1:0] A_MVIEW = IW'(2);
  localparam logic [IW-1:0] A_RAISE = IW'(3);
  localparam logic [IW-1:0] A_MASK  = IW'(4);
  localparam logic [IW-1:0] A_MSET  = IW'(5);
  localparam logic [IW-1:0] A_MCLR  = IW'(6);

  logic [W-1:0]  mode_q, cause_q, mask_q;
  logic [W-1:0]  mview, wr_clr, rd_clr, raise;
  logic [IW-1:0] widx;

  assign widx  = bus_addr[AW-1:2];
  assign mview = cause_q & ~mask_q;
  assign irq_o = |mview;

  wire wr_ack = bus_we && (widx == A_CAUSE || widx == A_MVIEW);
  assign wr_clr = wr_ack ? (bus_wdata & ~mode_q) : '0;
  assign raise  = evt_i | ((bus_we && widx == A_RAISE) ? bus_wdata : '0);

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      case (widx)
        A_MODE:  bus_rdata = mode_q;
        A_CAUSE: bus_rdata = cause_q;
        A_MVIEW: bus_rdata = mview;
        A_MASK:  bus_rdata = mask_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign rd_clr = (bus_re && (widx == A_CAUSE || widx == A_MVIEW)) ? (bus_rdata & mode_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      cause_q <= '0;
      mask_q  <= '1;
    end else begin
      cause_q <= (cause_q & ~(wr_clr | rd_clr)) | raise;
      if (bus_we && widx == A_MODE) mode_q <= bus_wdata;
      if (bus_we) begin
        case (widx)
          A_MASK:  mask_q <= bus_wdata;
          A_MSET:  mask_q <= mask_q | bus_wdata;
          A_MCLR:  mask_q <= mask_q & ~bus_wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

module irq_cause_bank_chk #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  evt_i,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic [W-1:0]  bus_wdata,
  input logic          bus_re,
  input logic [W-1:0]  cause,
  input logic [W-1:0]  mask,
  input logic [W-1:0]  mode,
  input logic          irq_o
);
  logic [AW-3:0] ix;
  assign ix = bus_addr[AW-1:2];

  // R1
  always @(negedge clk)
    if (!rst_n) reset_state_chk: assert (cause == '0 && mask == '1 && mode == '0 && !irq_o);

  // R2
  event_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((cause & $past(evt_i)) == $past(evt_i)));

  // R3
  w1c_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && ix == 1 && evt_i == '0) |=> ((cause & $past(bus_wdata & ~mode)) == '0));

  // R4
  cor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !bus_we && ix == 1 && evt_i == '0) |=> ((cause & $past(cause & mode)) == '0));

  // R8
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && ix == 5) |=> ((mask & $past(bus_wdata)) == $past(bus_wdata)));

  // R8
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && ix == 6) |=> ((mask & $past(bus_wdata)) == '0));

  // R10
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq_o);

  // R11
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && ix == 0) |=> (mode == $past(bus_wdata)));
endmodule

bind irq_cause_bank irq_cause_bank_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_addr(bus_addr),
  .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re),
  .cause(cause_q), .mask(mask_q), .mode(mode_q), .irq_o(irq_o)
);

// File: tb/tb_irq_cause_bank.sv
`timescale 1ns/1ps
module tb_irq_cause_bank;
  logic        clk = 0, rst_n = 0;
  logic [31:0] evt_i = 0, bus_wdata = 0;
  logic [4:0]  bus_addr = 0;
  logic        bus_we = 0, bus_re = 0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int checks = 0, errors = 0;
  logic [31:0] m_mode = 0, m_cause = 0, m_mask = '1;

  irq_cause_bank dut (.*);

  always #2.5 clk = ~clk;

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    case (a[4:2])
      3'd0: return m_mode;
      3'd1: return m_cause;
      3'd2: return m_cause & ~m_mask;
      3'd4: return m_mask;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, re, input logic [4:0] a, input logic [31:0] d, ev, input string tag);
    logic [31:0] er, clr, nc;
    @(posedge clk); #1;
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d; evt_i = ev;
    @(negedge clk);
    er = re ? exp_rd(a) : 32'h0;
    if (re) check(bus_rdata === er, tag, bus_rdata, er);
    check(irq_o === |(m_cause & ~m_mask), "R10", {31'h0, irq_o}, {31'h0, |(m_cause & ~m_mask)});
    clr = 0;
    if (we && (a[4:2] == 1 || a[4:2] == 2)) clr |= d & ~m_mode;
    if (re && (a[4:2] == 1 || a[4:2] == 2)) clr |= er & m_mode;
    nc = (m_cause & ~clr) | ev | ((we && a[4:2] == 3) ? d : 32'h0);
    if (we) case (a[4:2])
      3'd0: m_mode = d;
      3'd4: m_mask = d;
      3'd5: m_mask = m_mask | d;
      3'd6: m_mask = m_mask & ~d;
      default: ;
    endcase
    m_cause = nc;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
    step(1, 0, a, d, 0, tag);
  endtask
  task automatic rd(input logic [4:0] a, input string tag);
    step(0, 1, a, 0, 0, tag);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(5'h00, "R1"); rd(5'h04, "R1"); rd(5'h10, "R1");
    // R11 mode word
    wr(5'h00, 32'h0000FFFF, "R11"); rd(5'h00, "R11");
    // R2 events latch
    step(0, 0, 0, 0, 32'h80000001, "R2");
    rd(5'h08, "R7"); // still masked: view is 0
    // R3 write clears W1C bit 31, COR bit 0 unaffected; R4 read clears bit 0
    wr(5'h04, 32'hFFFFFFFF, "R3");
    rd(5'h04, "R4"); rd(5'h04, "R4");
    // R6 raise and write-only reads
    wr(5'h0C, 32'h00F00F00, "R6");
    rd(5'h0C, "R6"); rd(5'h14, "R6"); rd(5'h18, "R6"); rd(5'h1C, "R6");
    rd(5'h04, "R4"); rd(5'h04, "R6");
    // R7 mask direct write, R10 irq rises
    wr(5'h10, 32'h0, "R7"); rd(5'h10, "R7"); rd(5'h08, "R5");
    // R8 mask set/clear
    wr(5'h14, 32'h00F00000, "R8"); rd(5'h10, "R8"); rd(5'h08, "R5");
    wr(5'h18, 32'h00300000, "R8"); rd(5'h10, "R8");
    // R5 masked read clears COR visible bits only
    wr(5'h00, 32'h00100000, "R11");
    rd(5'h08, "R5"); rd(5'h04, "R5");
    // R9 event wins over a write clear of the same bit
    step(1, 0, 5'h04, 32'h00200000, 32'h00200000, "R9");
    rd(5'h04, "R9");
    // R9 event wins over a read clear
    wr(5'h0C, 32'h00100000, "R9");
    step(0, 1, 5'h04, 0, 32'h00100000, "R9");
    rd(5'h04, "R9");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] a;
      logic [31:0] d, ev;
      int op;
      a = {$urandom_range(0, 7)}[4:0] << 2;
      a[1:0] = 2'($urandom);
      d = $urandom;
      if ($urandom_range(0, 3) == 0) d = d & $urandom;
      ev = ($urandom_range(0, 2) == 0) ? ($urandom & $urandom & $urandom) : 32'h0;
      op = $urandom_range(0, 3);
      step(op == 0 || op == 3, op == 1 || op == 3, a, d, ev, "R3/R4 random");
    end
    step(0, 0, 0, 0, 0, "idle");
    finish_run();
  end
endmodule